// File: doc/BRIEF.md
# Stepped Soft-Start Current Limit Sequencer

This block sets the current-limit level of a boost converter's power switch while the converter starts up. Out of reset the limit sits at one ninth of full scale. It then climbs one ninth at a time until it reaches full scale. A step is due once a fixed number of millisecond ticks has passed since the previous step. With the defaults that is two ticks, which gives a ramp of roughly 16 ms.

A step taken while the LED strings carry no current would let the inductor current climb with no load to show for it. For that reason each step also waits until some LED string has conducted since the last step. The conduction flag comes from the dimming PWM and the channel states. When the interval has already run out, the step fires on the first cycle that conduction appears. Dropping the enable and raising it again starts the ramp over from the lowest level.

The output is a small binary code for the analog current-limit reference, plus a done flag that holds once full scale is reached.

Top module: `ilim_ramp_seq`

## Requirements
- R1: While `rst` is high, the outputs are `ilim_code` = 1 and `ramp_done` = 0, the tick count is cleared and any recorded conduction is forgotten.
- R2: `ilim_code` is a 4-bit unsigned value from 1 to 9, where k means k ninths of the full limit. It changes only by +1 per step, so the ramp has exactly 8 steps.
- R3: A step needs two rising-edge-sampled `tick_ms` pulses, counted since the previous step, since reset, or since enable was last raised. A single tick never causes a step.
- R4: A step needs conduction since the previous step. This is `led_on` high in any earlier cycle of the interval (held in a sticky flag) or in the current cycle. Without it, the code stays put no matter how many ticks arrive.
- R5: Once the interval has elapsed with no conduction, the first cycle with `led_on` high causes the step. The new code appears after the next rising clock edge.
- R6: Taking a step clears the sticky conduction flag and restarts the tick count. Conduction seen only before a step does not qualify the step after it.
- R7: When conduction has already been recorded, the code increments on the rising edge that follows the edge on which the second tick is counted.
- R8: `ramp_done` is high exactly when `ilim_code` is 9. The code then holds at 9 under any further ticks and conduction.
- R9: While `enable` is low, the code is forced to 1, ticks are not counted and conduction is not recorded. After enable rises, the full ramp restarts from 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | LED enable; low restarts the ramp |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| led_on | input | 1 | High while any LED string conducts |
| ilim_code | output | 4 | Current-limit level in ninths (1 to 9) |
| ramp_done | output | 1 | High when the limit is at full scale |

## Verification
Every result is registered. The tick count updates on the edge that samples `tick_ms`, and the code updates one edge after the step condition becomes true. A qualified step is therefore visible one full cycle after the second tick is counted, or one cycle after the first `led_on` pulse when a stalled interval is waiting. All inputs change on falling edges and all samples are taken on falling edges. Each check waits exactly the number of edges above before sampling. It also checks one edge earlier that the code has not yet moved, which pins down the latency. Stalls are checked after many extra ticks and idle cycles, so that a missing stall would have had time to show up.

// File: rtl/ilim_ramp_pkg.sv
package ilim_ramp_pkg;

    // Step request: the interval has elapsed and conduction qualifies it.
    typedef struct packed {
        logic due;
        logic conduct;
    } step_req_t;

    // Width needed to hold levels 1 .. steps+1.
    function automatic int code_width(input int steps);
        return $clog2(steps + 2);
    endfunction

    // Width needed to hold a tick count 0 .. ticks.
    function automatic int count_width(input int ticks);
        return $clog2(ticks + 1);
    endfunction

    // A step fires only when due, qualified, and below full scale.
    function automatic logic step_fire(input step_req_t req, input logic at_top);
        return req.due && req.conduct && !at_top;
    endfunction

endpackage

// File: rtl/ilim_interval_timer.sv
module ilim_interval_timer #(
    parameter int TICKS = 2,
    parameter int CNT_W = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic tick_ms,
    input  logic step,
    output logic due
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TICKS);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= '0;
        end else if (tick_ms && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign due = (cnt_q == LIMIT);

    // R3: the count never passes the interval length
    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);

    // R6: after a step the count starts over
    a_r6_count_restart: assert property (@(posedge clk) disable iff (rst)
        (step && enable) |=> (cnt_q == '0));

endmodule

// File: rtl/ilim_cond_latch.sv
module ilim_cond_latch (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic led_on,
    input  logic step,
    output logic conduct
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            seen_q <= 1'b0;
        end else if (step) begin
            seen_q <= 1'b0;
        end else if (led_on) begin
            seen_q <= 1'b1;
        end
    end

    assign conduct = seen_q | led_on;

    // R6: a step consumes the recorded conduction
    a_r6_sticky_clear: assert property (@(posedge clk) disable iff (rst)
        step |=> !seen_q);

    // R4: conduction is recorded until a step takes it
    a_r4_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (led_on && enable && !step) |=> seen_q);

endmodule

// File: rtl/ilim_level_reg.sv
module ilim_level_reg #(
    parameter int STEPS  = 8,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              step,
    output logic [CODE_W-1:0] code,
    output logic              at_top
);
    localparam logic [CODE_W-1:0] TOP  = CODE_W'(STEPS + 1);
    localparam logic [CODE_W-1:0] BASE = CODE_W'(1);

    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            code_q <= BASE;
        end else if (step && (code_q != TOP)) begin
            code_q <= code_q + 1'b1;
        end
    end

    assign code   = code_q;
    assign at_top = (code_q == TOP);

    // R2: level stays inside 1 .. full scale
    a_r2_code_range: assert property (@(posedge clk) disable iff (rst)
        (code_q >= BASE) && (code_q <= TOP));

    // R2: level moves by one ninth or restarts at the base
    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        (code_q != $past(code_q)) |-> ((code_q == $past(code_q) + 1'b1) || (code_q == BASE)));

    // R8: full scale is reached only from the level just below
    a_r8_done_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(at_top) |-> ($past(code_q) == TOP - 1'b1));

    // R9: a low enable restarts the ramp
    a_r9_disable_base: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (code_q == BASE));

endmodule

// File: rtl/ilim_ramp_seq.sv
module ilim_ramp_seq #(
    parameter int STEPS = 8,
    parameter int TICKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       tick_ms,
    input  logic       led_on,
    output logic [3:0] ilim_code,
    output logic       ramp_done
);
    import ilim_ramp_pkg::*;

    localparam int CODE_W = code_width(STEPS);
    localparam int CNT_W  = count_width(TICKS);

    step_req_t         req;
    logic              step;
    logic              at_top;
    logic [CODE_W-1:0] level;

    ilim_interval_timer #(.TICKS(TICKS), .CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .tick_ms (tick_ms),
        .step    (step),
        .due     (req.due)
    );

    ilim_cond_latch u_cond (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .led_on  (led_on),
        .step    (step),
        .conduct (req.conduct)
    );

    ilim_level_reg #(.STEPS(STEPS), .CODE_W(CODE_W)) u_level (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .step   (step),
        .code   (level),
        .at_top (at_top)
    );

    assign step      = step_fire(req, at_top) && enable;
    assign ilim_code = 4'(level);
    assign ramp_done = at_top;

    // R4: every increase was qualified by due interval and conduction
    a_r4_qualified_step: assert property (@(posedge clk) disable iff (rst)
        (enable && (ilim_code == $past(ilim_code) + 1'b1)) |-> $past(req.due && req.conduct));

    // R5: a due interval with conduction present advances next cycle
    a_r5_prompt_step: assert property (@(posedge clk) disable iff (rst)
        (enable && req.due && led_on && !ramp_done) |=> (ilim_code == $past(ilim_code) + 1'b1) || !enable || rst);

    // R8: full scale holds while enabled
    a_r8_hold_top: assert property (@(posedge clk) disable iff (rst)
        (ramp_done && enable) |=> (ramp_done || !enable));

endmodule

// File: tb/ilim_ramp_seq_test.sv
module ilim_ramp_seq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b1;
    logic       tick_ms = 1'b0;
    logic       led_on = 1'b0;
    logic [3:0] ilim_code;
    logic       ramp_done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ilim_ramp_seq uut (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .tick_ms   (tick_ms),
        .led_on    (led_on),
        .ilim_code (ilim_code),
        .ramp_done (ramp_done)
    );

    task automatic chk(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic tick_pulse();
        @(negedge clk) tick_ms = 1'b1;
        @(negedge clk) tick_ms = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk) enable = 1'b0;
        @(negedge clk) enable = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        chk("R1 code in reset", ilim_code, 1);
        chk("R1 done in reset", ramp_done, 0);
        @(negedge clk) rst = 1'b0;

        // R7 R2 R8: continuous conduction, full ramp
        led_on = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            tick_pulse();
            chk("R3 one tick no step", ilim_code, k);
            tick_pulse();
            chk("R7 not before next edge", ilim_code, k);
            idle(1);
            chk("R7 step after second tick", ilim_code, k + 1);
            chk("R8 done flag", ramp_done, (k + 1 == 9) ? 1 : 0);
        end
        for (int j = 0; j < 6; j++) tick_pulse();
        idle(2);
        chk("R8 holds at full", ilim_code, 9);
        chk("R8 done holds", ramp_done, 1);

        // R9: disable restarts; ticks while disabled ignored
        @(negedge clk) enable = 1'b0;
        idle(1);
        chk("R9 disable forces base", ilim_code, 1);
        chk("R9 done clears", ramp_done, 0);
        for (int j = 0; j < 4; j++) tick_pulse();
        idle(2);
        chk("R9 ticks ignored while low", ilim_code, 1);
        @(negedge clk) enable = 1'b1;
        tick_pulse();
        idle(2);
        chk("R9 fresh interval after enable", ilim_code, 1);
        tick_pulse();
        idle(1);
        chk("R9 ramp restarts", ilim_code, 2);

        // R4 R5: stall without conduction, then prompt step
        led_on = 1'b0;
        for (int j = 0; j < 5; j++) tick_pulse();
        idle(10);
        chk("R4 stalled without conduction", ilim_code, 2);
        @(negedge clk) led_on = 1'b1;
        @(negedge clk) led_on = 1'b0;
        chk("R5 step on first conduction", ilim_code, 3);

        // R6: previous conduction consumed by the step
        tick_pulse();
        tick_pulse();
        idle(4);
        chk("R6 sticky cleared by step", ilim_code, 3);

        // R4: short pulse early in interval qualifies later step
        @(negedge clk) led_on = 1'b1;
        @(negedge clk) led_on = 1'b0;
        // interval already elapsed above: pulse stepped immediately
        chk("R5 pulse on due interval", ilim_code, 4);
        @(negedge clk) led_on = 1'b1;
        @(negedge clk) led_on = 1'b0;
        idle(3);
        chk("R3 pulse alone no step", ilim_code, 4);
        tick_pulse();
        tick_pulse();
        idle(1);
        chk("R4 sticky conduction qualifies", ilim_code, 5);

        // R1: reset mid-ramp clears level and partial interval
        led_on = 1'b1;
        tick_pulse();
        @(negedge clk) rst = 1'b1;
        idle(1);
        chk("R1 reset mid-ramp", ilim_code, 1);
        @(negedge clk) rst = 1'b0;
        tick_pulse();
        idle(2);
        chk("R1 interval cleared by reset", ilim_code, 1);
        tick_pulse();
        idle(1);
        chk("R7 step after reset", ilim_code, 2);

        // R1: recorded conduction forgotten by restart
        led_on = 1'b0;
        tick_pulse();
        @(negedge clk) led_on = 1'b1;
        @(negedge clk) led_on = 1'b0;
        restart();
        chk("R9 restart to base", ilim_code, 1);
        tick_pulse();
        tick_pulse();
        idle(3);
        chk("R1 conduction forgotten", ilim_code, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule